// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block decides where a small 8-bit controller fetches next after a branch. Each cycle with `valid_i` high, it takes the branch's own address, a branch class code, the selector bits held in the opcode, the second instruction byte, the accumulator, one working register and five condition flags. On the clock edge it registers the resulting program counter. For the decrement-and-test branch it also registers the decremented register value, together with a one-cycle write strobe.

The program space is 2K words. It is split into eight pages of 256 words each. Conditional branches can only retarget the low byte, so they stay inside the page that holds the branch. The long jump takes its page from three opcode bits. The indirect jump reads its target byte from program memory: the block drives that address on `mem_addr_o` and receives the fetched byte on `mem_data_i` in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o`, `reg_wr_o` and `reg_wdata_o` are all zero.
- R2: Class 0 (long jump): one clock after a valid cycle, `pc_o` = {`sel_i`, `addr_i`}, where `sel_i` forms bits 10..8.
- R3: Class 1 (indirect jump): `mem_addr_o` = {`pc_i`[10:8], `acc_i`} combinationally. One clock later, `pc_o` = {`pc_i`[10:8], `mem_data_i`}.
- R4: Class 2 (bit test) is taken exactly when `acc_i[sel_i]` is 1.
- R5: Class 3 is taken when `c_i` is 1. Class 4 is taken when `c_i` is 0.
- R6: Class 5 is taken on `f0_i`=1. Class 6 is taken on `f1_i`=1. Class 7 is taken on `ibf_i`=0. Class 8 is taken on `obf_i`=1.
- R7: A taken conditional branch (classes 2..9) gives `pc_o` = {`pc_i`[10:8], `addr_i`}.
- R8: A not-taken conditional branch gives `pc_o` = {`pc_i`[10:8], (`pc_i`[7:0]+2) mod 256`}. The page bits never carry, so 0x2FE becomes 0x200.
- R9: Class 9 (decrement and test) pulses `reg_wr_o` for one cycle with `reg_wdata_o` = (`reg_i`−1) mod 256. This write happens whether the branch is taken or not. The branch is taken when that result is nonzero, so 0x01 falls through and 0x00 jumps.
- R10: Classes 10..15 act as not-taken branches, as in R8, and do not assert `reg_wr_o`.
- R11: In a cycle with `valid_i` low, `pc_o` holds its value and `reg_wr_o` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A branch is presented this cycle |
| op_i | input | 4 | Branch class code |
| pc_i | input | 11 | Address of the branch instruction |
| sel_i | input | 3 | Opcode selector: page bits or accumulator bit index |
| addr_i | input | 8 | Second instruction byte |
| acc_i | input | 8 | Accumulator |
| reg_i | input | 8 | Working register for decrement and test |
| c_i | input | 1 | Carry flag |
| f0_i | input | 1 | User flag 0 |
| f1_i | input | 1 | User flag 1 |
| ibf_i | input | 1 | Input buffer full flag |
| obf_i | input | 1 | Output buffer full flag |
| mem_addr_o | output | 11 | Program memory address for the indirect jump |
| mem_data_i | input | 8 | Program memory byte at `mem_addr_o` |
| pc_o | output | 11 | Registered next program counter |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Decremented register value |

## Verification
The bench sweeps every class code against all flag combinations and all selector values. It uses branch addresses at the bottom of a page, at 0x2FE and 0x7FF, so that the fall-through add wraps.
- A design that lets the page carry would land at 0x300 instead of 0x200.
- A design that builds the indirect address from anything other than the branch's page would fetch a different byte, and the target would be wrong.
- Register values 0x00, 0x01, 0x02 and 0xFF catch an inverted zero test, and a write-back that depends on whether the branch is taken.
- Idle cycles placed between branches would expose a PC that drifts, or a write strobe that stays high.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    BR_LONG    = 4'd0,
    BR_IND     = 4'd1,
    BR_ABIT    = 4'd2,
    BR_CY      = 4'd3,
    BR_NCY     = 4'd4,
    BR_FLAG0   = 4'd5,
    BR_FLAG1   = 4'd6,
    BR_INFREE  = 4'd7,
    BR_OUTFULL = 4'd8,
    BR_DECNZ   = 4'd9
  } br_op_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval import npc_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  br_op_e            op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] reg_dec_i,
  input  logic              c_i,
  input  logic              f0_i,
  input  logic              f1_i,
  input  logic              ibf_i,
  input  logic              obf_i,
  output logic              taken_o
);
  logic acc_bit;
  assign acc_bit = acc_i[sel_i];

  always_comb begin
    unique case (op_i)
      BR_ABIT:    taken_o = acc_bit;
      BR_CY:      taken_o = c_i;
      BR_NCY:     taken_o = ~c_i;
      BR_FLAG0:   taken_o = f0_i;
      BR_FLAG1:   taken_o = f1_i;
      BR_INFREE:  taken_o = ~ibf_i;
      BR_OUTFULL: taken_o = obf_i;
      BR_DECNZ:   taken_o = |reg_dec_i;
      default:    taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target import npc_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int SEL_W  = $clog2(DATA_W),
  localparam int ADDR_W = DATA_W + SEL_W
) (
  input  br_op_e            op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              taken_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic [SEL_W-1:0]  page;
  logic [DATA_W-1:0] low_step;

  assign page = pc_i[ADDR_W-1:DATA_W];
  // fall-through wraps inside the page
  assign low_step = pc_i[DATA_W-1:0] + DATA_W'(2);

  always_comb begin
    unique case (op_i)
      BR_LONG: next_pc_o = {sel_i, addr_i};
      BR_IND:  next_pc_o = {page, mem_data_i};
      default: next_pc_o = taken_i ? {page, addr_i} : {page, low_step};
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit import npc_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int SEL_W  = $clog2(DATA_W),
  localparam int ADDR_W = DATA_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic              c_i,
  input  logic              f0_i,
  input  logic              f1_i,
  input  logic              ibf_i,
  input  logic              obf_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  br_op_e            op;
  logic [DATA_W-1:0] reg_dec;
  logic              taken;
  logic [ADDR_W-1:0] next_pc;

  assign op         = br_op_e'(op_i);
  assign reg_dec    = reg_i - DATA_W'(1);
  assign mem_addr_o = {pc_i[ADDR_W-1:DATA_W], acc_i};

  npc_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .op_i      (op),
    .acc_i     (acc_i),
    .sel_i     (sel_i),
    .reg_dec_i (reg_dec),
    .c_i       (c_i),
    .f0_i      (f0_i),
    .f1_i      (f1_i),
    .ibf_i     (ibf_i),
    .obf_i     (obf_i),
    .taken_o   (taken)
  );

  npc_target #(.DATA_W(DATA_W)) u_tgt (
    .op_i       (op),
    .pc_i       (pc_i),
    .sel_i      (sel_i),
    .addr_i     (addr_i),
    .mem_data_i (mem_data_i),
    .taken_i    (taken),
    .next_pc_o  (next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o        <= '0;
      reg_wr_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_wr_o <= valid_i && (op == BR_DECNZ);
      if (valid_i) begin
        pc_o <= next_pc;
        if (op == BR_DECNZ) reg_wdata_o <= reg_dec;
      end
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int DATA_W = 8,
  localparam int SEL_W  = $clog2(DATA_W),
  localparam int ADDR_W = DATA_W + SEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [DATA_W-1:0] addr_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] reg_i,
  input logic              c_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              reg_wr_o,
  input logic [DATA_W-1:0] reg_wdata_o
);
  // R2
  long_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0) |=> pc_o == {$past(sel_i), $past(addr_i)});

  // R3
  ind_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_addr_o[DATA_W-1:0] == acc_i && mem_addr_o[ADDR_W-1:DATA_W] == pc_i[ADDR_W-1:DATA_W]);

  // R5
  carry_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3 && c_i) |=>
      pc_o == {$past(pc_i[ADDR_W-1:DATA_W]), $past(addr_i)});

  // R8
  page_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 4'd0) |=> pc_o[ADDR_W-1:DATA_W] == $past(pc_i[ADDR_W-1:DATA_W]));

  // R9
  dec_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9) |=> reg_wr_o && reg_wdata_o == DATA_W'($past(reg_i) - 1'b1));

  // R9
  dec_one_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9 && reg_i == DATA_W'(1)) |=>
      pc_o[DATA_W-1:0] == DATA_W'($past(pc_i[DATA_W-1:0]) + 2'd2));

  // R10
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i == 4'd9) |=> !reg_wr_o);

  // R11
  hold_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (pc_o == '0 && !reg_wr_o && reg_wdata_o == '0);
    end
  end
endmodule

bind npc_unit npc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .pc_i        (pc_i),
  .sel_i       (sel_i),
  .addr_i      (addr_i),
  .acc_i       (acc_i),
  .reg_i       (reg_i),
  .c_i         (c_i),
  .mem_addr_o  (mem_addr_o),
  .pc_o        (pc_o),
  .reg_wr_o    (reg_wr_o),
  .reg_wdata_o (reg_wdata_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [10:0] pc = '0;
  logic [2:0]  sel = '0;
  logic [7:0]  addr = '0, acc = '0, rgv = '0;
  logic        c = 0, f0 = 0, f1 = 0, ibf = 0, obf = 0;
  logic [10:0] mem_addr;
  logic [7:0]  mem_data;
  logic [10:0] pc_out;
  logic        reg_wr;
  logic [7:0]  reg_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'b10110};
  endfunction

  assign mem_data = mem_f(mem_addr);

  npc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .pc_i(pc),
    .sel_i(sel), .addr_i(addr), .acc_i(acc), .reg_i(rgv), .c_i(c),
    .f0_i(f0), .f1_i(f1), .ibf_i(ibf), .obf_i(obf),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .pc_o(pc_out), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (op %0d pc %h sel %0d)", req, act, exp, op, pc, sel);
    end
  endtask

  function automatic bit exp_taken(input int k);
    case (k)
      2: return acc[sel];             // R4
      3: return c;                    // R5
      4: return !c;                   // R5
      5: return f0;                   // R6
      6: return f1;                   // R6
      7: return !ibf;                 // R6
      8: return obf;                  // R6
      9: return (rgv - 8'd1) != 8'd0; // R9
      default: return 1'b0;           // R10
    endcase
  endfunction

  function automatic logic [10:0] exp_pc(input int k);
    logic [7:0] lo2;
    lo2 = pc[7:0] + 8'd2;
    if (k == 0) return {sel, addr};                         // R2
    if (k == 1) return {pc[10:8], mem_f({pc[10:8], acc})};  // R3
    if (exp_taken(k)) return {pc[10:8], addr};              // R7
    return {pc[10:8], lo2};                                 // R8
  endfunction

  initial begin
    logic [10:0] pcs [4];
    logic [7:0]  regs [4];
    logic [10:0] held;
    pcs[0] = 11'h000; pcs[1] = 11'h2FE; pcs[2] = 11'h7FF; pcs[3] = 11'h4A3;
    regs[0] = 8'h00; regs[1] = 8'h01; regs[2] = 8'h02; regs[3] = 8'hFF;
    #3;
    chk("R1 pc", 16'(pc_out), 16'h0);
    chk("R1 wr", 16'(reg_wr), 16'h0);
    chk("R1 wdata", 16'(reg_wdata), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int fl = 0; fl < 32; fl++) begin
          for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            valid = 1'b1;
            op = 4'(k); pc = pcs[p]; sel = 3'(s);
            {obf, ibf, f1, f0, c} = 5'(fl);
            addr = 8'(fl * 37 + s * 11 + 5);
            acc = 8'(fl * 7 + s * 29 + p + 1);
            rgv = regs[(fl + s) % 4];
            @(negedge clk);
            if (k == 1) chk("R3 mem_addr", 16'(mem_addr), 16'({pc[10:8], acc}));
            case (k)
              0: chk("R2", 16'(pc_out), 16'(exp_pc(k)));
              1: chk("R3", 16'(pc_out), 16'(exp_pc(k)));
              9: chk("R9 pc", 16'(pc_out), 16'(exp_pc(k)));
              default: chk(k >= 10 ? "R10" : (exp_taken(k) ? "R7" : "R8"),
                           16'(pc_out), 16'(exp_pc(k)));
            endcase
            chk(k == 9 ? "R9 wr" : "R10 wr", 16'(reg_wr), 16'(k == 9));
            if (k == 9) chk("R9 wdata", 16'(reg_wdata), 16'(8'(rgv - 8'd1)));
            if (s == 7 && (fl % 8) == 3) begin
              held = pc_out;
              valid = 1'b0;
              op = 4'd9; pc = 11'h5A5; addr = 8'h3C;
              @(negedge clk);
              chk("R11 pc", 16'(pc_out), 16'(held));
              chk("R11 wr", 16'(reg_wr), 16'h0);
            end
          end
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule